// File: doc/BRIEF.md
# Two-Bus Processor Datapath

This block is the processing unit of a small stored-program computer. It holds the instruction register, the memory address register, the program counter, two general-purpose registers X and Y, the ALU operand register Z, an eight-function ALU and a four-bit flag register. An external sequencer drives every load enable, both bus selects and the ALU function code. In return the block reports the current opcode and the flags.

Data moves over two multiplexed buses. The first bus carries the program counter or one of the general registers. It drives the memory write-data port, feeds the second bus and supplies the ALU's second operand. The second bus carries the ALU result, the first bus or the memory read data, and it is the only path into every register. The memory address comes straight from the address register. The program counter has no adder of its own: an increment is a trip through the first bus, the ALU and back over the second bus.

Top module: `twobus_datapath`

## Requirements
- R1: When `rst` is high at a rising edge, every register clears. After reset, `opcode`, `mem_addr`, `flags` and `mem_wdata` (with the first bus on the PC) all read 0.
- R2: The first bus selects its source with `b1_sel`: 0 = PC, 1 = X, 2 = Y, 3 = constant zero. It appears combinationally on `mem_wdata`.
- R3: The second bus selects its source with `b2_sel`: 0 = ALU result, 1 = first bus, 2 = `mem_rdata`, 3 = constant zero. Each of IR, MAR, PC, X, Y and Z loads from the second bus at a rising edge when its own enable is high, and holds otherwise.
- R4: The ALU takes A = Z and B = first bus. `alu_op` selects the function: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 B+1, 6 B, 7 ~B. All results are 8-bit wrapping.
- R5: `flags` is {N, Z, V, C}, with N in bit 3 and C in bit 0. N equals result bit 7, and Z is set when the result is zero.
- R6: For the add function, C is the carry out and V is signed overflow. For the subtract function, C is set on a borrow (A < B unsigned) and V is signed overflow. For the increment function, C is set when B = 8'hFF and V when B = 8'h7F. For functions 2, 3, 4, 6 and 7, both C and V are 0.
- R7: The flag register loads the ALU flags only when `ld_ccr` is high. Otherwise it keeps its value whatever the ALU computes.
- R8: With the PC on the first bus, function 5, the ALU on the second bus and `ld_pc` high, the PC advances by one per cycle and wraps from 8'hFF to 8'h00.
- R9: `opcode` always shows the IR and `mem_addr` always shows the MAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| b1_sel | input | 2 | First-bus source select |
| b2_sel | input | 2 | Second-bus source select |
| alu_op | input | 3 | ALU function code |
| ld_ir | input | 1 | Instruction register load |
| ld_mar | input | 1 | Address register load |
| ld_pc | input | 1 | Program counter load |
| ld_x | input | 1 | X register load |
| ld_y | input | 1 | Y register load |
| ld_z | input | 1 | Operand register load |
| ld_ccr | input | 1 | Flag register load |
| mem_rdata | input | 8 | Data read from memory |
| mem_addr | output | 8 | Memory address (MAR) |
| mem_wdata | output | 8 | Memory write data (first bus) |
| opcode | output | 8 | IR contents to the sequencer |
| flags | output | 4 | {N,Z,V,C} to the sequencer |

## Verification
Directed operand pairs are chosen at the flag edges:
- 7F+01 gives signed overflow without carry.
- An increment of FF gives carry with a zero result.
- 7F−FF sets borrow and overflow together.
- An AND with the flags loaded shows that C and V clear.
- An add with `ld_ccr` low separates a flag update from a plain data transfer.

Beyond the operand pairs, these sequences are covered:
- Repeated PC increments, and an increment from FF, show the ALU return path and its wrap.
- Loads of IR and MAR from memory and from the first bus show that each source reaches the right register.
- The constant-zero selects are exercised on both buses.

A long run of random selects, functions, enables and read data is then compared cycle by cycle against a behavioural model. This run catches wrong mux codes, crossed enables and wrong function codes.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        B1_PC   = 2'd0,
        B1_X    = 2'd1,
        B1_Y    = 2'd2,
        B1_ZERO = 2'd3
    } b1_src_e;

    typedef enum logic [1:0] {
        B2_ALU  = 2'd0,
        B2_BUS1 = 2'd1,
        B2_MEM  = 2'd2,
        B2_ZERO = 2'd3
    } b2_src_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_INC  = 3'd5,
        OP_PASS = 3'd6,
        OP_NOT  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Index of each bus-loaded register in the register bank
    typedef enum int {
        RI_IR  = 0,
        RI_MAR = 1,
        RI_PC  = 2,
        RI_X   = 3,
        RI_Y   = 4,
        RI_Z   = 5
    } reg_idx_e;
    localparam int NREG = 6;

    function automatic logic arith_op(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
    endfunction
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       flg
);
    logic [W:0] wide;
    logic       carry, ovf;

    always_comb begin
        wide  = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        res   = '0;
        unique case (op)
            OP_ADD: begin
                wide  = {1'b0, a} + {1'b0, b};
                res   = wide[W-1:0];
                carry = wide[W];
                ovf   = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            OP_SUB: begin
                wide  = {1'b0, a} - {1'b0, b};
                res   = wide[W-1:0];
                carry = wide[W];
                ovf   = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
            end
            OP_INC: begin
                wide  = {1'b0, b} + {{W{1'b0}}, 1'b1};
                res   = wide[W-1:0];
                carry = wide[W];
                ovf   = ~b[W-1] & res[W-1];
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = b;
            OP_NOT:  res = ~b;
            default: res = '0;
        endcase
        flg.n = res[W-1];
        flg.z = (res == '0);
        flg.v = arith_op(op) ? ovf   : 1'b0;
        flg.c = arith_op(op) ? carry : 1'b0;
    end
endmodule

// File: rtl/dp_buses.sv
module dp_buses
    import dp_pkg::*;
#(
    parameter int W = DW
) (
    input  b1_src_e      s1,
    input  b2_src_e      s2,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] alu_res,
    input  logic [W-1:0] mem_rd,
    output logic [W-1:0] bus1,
    output logic [W-1:0] bus2
);
    always_comb begin
        unique case (s1)
            B1_PC:   bus1 = pc;
            B1_X:    bus1 = x;
            B1_Y:    bus1 = y;
            default: bus1 = '0;
        endcase
    end

    always_comb begin
        unique case (s2)
            B2_ALU:  bus2 = alu_res;
            B2_BUS1: bus2 = bus1;
            B2_MEM:  bus2 = mem_rd;
            default: bus2 = '0;
        endcase
    end
endmodule

// File: rtl/twobus_datapath.sv
module twobus_datapath
    import dp_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   b1_sel,
    input  logic [1:0]   b2_sel,
    input  logic [2:0]   alu_op,
    input  logic         ld_ir,
    input  logic         ld_mar,
    input  logic         ld_pc,
    input  logic         ld_x,
    input  logic         ld_y,
    input  logic         ld_z,
    input  logic         ld_ccr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic [W-1:0] opcode,
    output logic [3:0]   flags
);
    localparam int FW = $bits(flags_t);

    logic [W-1:0]    regq [NREG];
    logic [NREG-1:0] ld_vec;
    logic [W-1:0]    bus1, bus2, alu_res;
    flags_t          alu_flg, ccr_q;

    assign ld_vec[RI_IR]  = ld_ir;
    assign ld_vec[RI_MAR] = ld_mar;
    assign ld_vec[RI_PC]  = ld_pc;
    assign ld_vec[RI_X]   = ld_x;
    assign ld_vec[RI_Y]   = ld_y;
    assign ld_vec[RI_Z]   = ld_z;

    dp_buses #(.W(W)) u_buses (
        .s1      (b1_src_e'(b1_sel)),
        .s2      (b2_src_e'(b2_sel)),
        .pc      (regq[RI_PC]),
        .x       (regq[RI_X]),
        .y       (regq[RI_Y]),
        .alu_res (alu_res),
        .mem_rd  (mem_rdata),
        .bus1    (bus1),
        .bus2    (bus2)
    );

    dp_alu #(.W(W)) u_alu (
        .op  (alu_op_e'(alu_op)),
        .a   (regq[RI_Z]),
        .b   (bus1),
        .res (alu_res),
        .flg (alu_flg)
    );

    // Every bus-loaded register shares the second bus as its only input
    for (genvar i = 0; i < NREG; i++) begin : g_bank
        dp_reg #(.W(W)) u_r (
            .clk (clk),
            .rst (rst),
            .en  (ld_vec[i]),
            .d   (bus2),
            .q   (regq[i])
        );
    end

    dp_reg #(.W(FW)) u_ccr (
        .clk (clk),
        .rst (rst),
        .en  (ld_ccr),
        .d   (alu_flg),
        .q   (ccr_q)
    );

    assign mem_addr  = regq[RI_MAR];
    assign mem_wdata = bus1;
    assign opcode    = regq[RI_IR];
    assign flags     = ccr_q;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   b1_sel,
    input logic [1:0]   b2_sel,
    input logic [2:0]   alu_op,
    input logic         ld_ir,
    input logic         ld_mar,
    input logic         ld_pc,
    input logic         ld_x,
    input logic         ld_y,
    input logic         ld_z,
    input logic         ld_ccr,
    input logic [W-1:0] mem_rdata,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic [W-1:0] opcode,
    input logic [3:0]   flags
);
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_ir |=> $stable(opcode)); // R3

    AST_MAR_FROM_MEM: assert property (@(posedge clk) disable iff (rst)
        (ld_mar && b2_sel == 2'd2) |=> mem_addr == $past(mem_rdata)); // R3

    AST_IR_FROM_BUS1: assert property (@(posedge clk) disable iff (rst)
        (ld_ir && b2_sel == 2'd1) |=> opcode == $past(mem_wdata)); // R2

    AST_CCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_ccr |=> $stable(flags)); // R7

    AST_CV_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (ld_ccr && alu_op inside {3'd2, 3'd3, 3'd4, 3'd6, 3'd7}) |=> flags[1:0] == 2'b00); // R6

    AST_PASS_ZFLAG: assert property (@(posedge clk) disable iff (rst)
        (ld_ccr && alu_op == 3'd6) |=> flags[2] == ($past(mem_wdata) == '0)); // R5
endmodule

bind twobus_datapath dp_checker #(.W(W)) u_chk (.*);

// File: tb/tb_twobus_datapath.sv
`timescale 1ns/1ps
module tb_twobus_datapath;
    localparam int PER = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] b1_sel = '0, b2_sel = '0;
    logic [2:0] alu_op = '0;
    logic       ld_ir = 0, ld_mar = 0, ld_pc = 0, ld_x = 0, ld_y = 0, ld_z = 0, ld_ccr = 0;
    logic [7:0] mem_rdata = '0;
    logic [7:0] mem_addr, mem_wdata, opcode;
    logic [3:0] flags;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural model state
    int m_ir = 0, m_mar = 0, m_pc = 0, m_x = 0, m_y = 0, m_z = 0, m_f = 0;

    always #(PER/2) clk = ~clk;

    twobus_datapath dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int m_bus1(input int s);
        case (s)
            0: return m_pc;
            1: return m_x;
            2: return m_y;
            default: return 0;
        endcase
    endfunction

    task automatic m_alu(input int op, input int a, input int b, output int r, output int f);
        int raw, c, v, s;
        c = 0; v = 0;
        case (op)
            0: begin raw = a + b; c = (raw > 255); s = sgn(a) + sgn(b); v = (s > 127 || s < -128); end
            1: begin raw = a - b; c = (a < b);    s = sgn(a) - sgn(b); v = (s > 127 || s < -128); end
            2: raw = a & b;
            3: raw = a | b;
            4: raw = a ^ b;
            5: begin raw = b + 1; c = (b == 255); v = (b == 127); end
            6: raw = b;
            default: raw = 255 - b;
        endcase
        r = raw & 255;
        f = ((r >= 128) ? 8 : 0) + ((r == 0) ? 4 : 0) + v * 2 + c;
    endtask

    // lds = {ccr, z, y, x, pc, mar, ir}
    task automatic step(input int s1, input int s2, input int op, input logic [6:0] lds, input int md);
        int b1, b2, r, f;
        @(negedge clk);
        b1_sel = s1[1:0]; b2_sel = s2[1:0]; alu_op = op[2:0]; mem_rdata = md[7:0];
        {ld_ccr, ld_z, ld_y, ld_x, ld_pc, ld_mar, ld_ir} = lds;
        #1;
        b1 = m_bus1(s1);
        chk("R2 bus1 on mem_wdata", mem_wdata, b1);
        m_alu(op, m_z, b1, r, f);
        case (s2)
            0: b2 = r;
            1: b2 = b1;
            2: b2 = md;
            default: b2 = 0;
        endcase
        @(posedge clk); #1;
        if (lds[0]) m_ir = b2;
        if (lds[1]) m_mar = b2;
        if (lds[2]) m_pc = b2;
        if (lds[3]) m_x = b2;
        if (lds[4]) m_y = b2;
        if (lds[5]) m_z = b2;
        if (lds[6]) m_f = f;
        chk("R3/R9 opcode", opcode, m_ir);
        chk("R3/R9 mem_addr", mem_addr, m_mar);
        chk("R5 flags", flags, m_f);
    endtask

    task automatic peek(input int s1, output int v);
        @(negedge clk);
        b1_sel = s1[1:0];
        {ld_ccr, ld_z, ld_y, ld_x, ld_pc, ld_mar, ld_ir} = '0;
        #1;
        v = mem_wdata;
    endtask

    initial begin
        #(PER * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 opcode after reset", opcode, 0);
        chk("R1 mem_addr after reset", mem_addr, 0);
        chk("R1 flags after reset", flags, 0);
        chk("R1 pc via bus1 after reset", mem_wdata, 0);

        step(0, 2, 0, 7'b0100000, 8'h7F);          // Z = 7F
        step(0, 2, 0, 7'b0001000, 8'h01);          // X = 01
        step(1, 0, 0, 7'b1010000, 0);              // Y = 7F+01
        chk("R6 add overflow flags", flags, 4'hA);
        peek(2, v); chk("R4 add result in Y", v, 8'h80);

        step(0, 2, 0, 7'b0001000, 8'hFF);          // X = FF
        step(1, 0, 5, 7'b1010000, 0);              // Y = FF+1
        chk("R6 inc carry flags", flags, 4'h5);
        peek(2, v); chk("R4 inc wraps to zero", v, 0);

        step(1, 0, 1, 7'b1010000, 0);              // Y = 7F-FF
        chk("R6 sub borrow+overflow", flags, 4'hB);
        peek(2, v); chk("R4 sub result", v, 8'h80);

        step(1, 0, 2, 7'b1010000, 0);              // AND
        chk("R6 logic clears C,V", flags, 4'h0);
        peek(2, v); chk("R4 and result", v, 8'h7F);

        step(1, 0, 0, 7'b0010000, 0);              // add, flags not loaded
        chk("R7 flags held without ld_ccr", flags, 4'h0);
        peek(2, v); chk("R4 add without flag load", v, 8'h7E);

        step(0, 2, 0, 7'b0000100, 8'h00);          // PC = 0
        for (int i = 0; i < 3; i++) step(0, 0, 5, 7'b0000100, 0);
        peek(0, v); chk("R8 pc after three increments", v, 3);
        step(0, 2, 0, 7'b0000100, 8'hFF);
        step(0, 0, 5, 7'b0000100, 0);
        peek(0, v); chk("R8 pc wraps FF->00", v, 0);

        step(0, 2, 0, 7'b0000001, 8'hA5);
        chk("R9 opcode from memory", opcode, 8'hA5);
        step(0, 2, 0, 7'b0000100, 8'h42);
        step(0, 1, 0, 7'b0000010, 0);
        chk("R9 mar from pc via bus1", mem_addr, 8'h42);

        peek(3, v); chk("R2 bus1 zero select", v, 0);
        step(0, 3, 0, 7'b0001000, 8'h99);
        peek(1, v); chk("R3 bus2 zero select into X", v, 0);

        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7),
                 7'($urandom), $urandom_range(0, 255));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule